// File: doc/BRIEF.md
# Memory Error Capture and Interrupt Unit

This unit sits beside a memory controller and records three kinds of access fault: an address that decodes to no memory, an access that hits an invalid page of the translation table, and an access that breaks a security rule. The fault detectors are outside the unit. Each one delivers a single-cycle pulse with the client ID, the direction and the faulting address. Security faults also carry a subtype bit.

For each kind there is one capture slot. The slot holds a status word and an address word, and it sets one bit in an interrupt status word. The slot keeps the first fault it sees until software clears that kind's bit by writing a one to it. A mask word selects which pending bits drive the registered interrupt output. Software reads and writes all of this through a small word-indexed register port. A read returns its data one cycle after the request.

Top module: `memerr_unit`

## Requirements
- R1: Synchronous reset clears the following: every pending bit, the mask word, the interrupt output, the read-valid output, and every captured status and address word.
- R2: A decode fault captures a status word in which bits 5:0 hold the client ID and bit 31 is 1 for a write and 0 for a read. All other bits are 0. It is read at index 2.
- R3: An invalid-page fault captures a status word in which bit 0 is 1 for a write and 0 for a read, and bits 6:1 hold the client ID. All other bits are 0. It is read at index 4.
- R4: A security fault captures a status word in which bits 5:0 hold the client ID, bit 30 holds the subtype and bit 31 is 1 for a write. All other bits are 0. It is read at index 6.
- R5: The faulting address is captured, zero-extended to 32 bits, in the word at the index directly after its kind's status word (indices 3, 5 and 7).
- R6: A fault sets its pending bit in the interrupt status word at index 0: bit 0 for decode, bit 1 for invalid page, bit 2 for security. Faults of several kinds in one cycle set all their bits.
- R7: While a kind's pending bit is set, further faults of that kind change neither its status word nor its address word.
- R8: Writing index 0 clears exactly those pending bits whose written bit is 1. Bits written as 0 keep their state.
- R9: If a fault arrives in the same cycle as a write that clears its kind's bit, the new fault is captured and the bit stays set.
- R10: The mask word at index 1 (bits 2:0, reset 0) is read/write. One cycle after any pending bit and its mask bit are both 1, the irq output is 1. One cycle after no such pair exists, irq is 0.
- R11: A read request at any index returns its data on reg_rdata with reg_rd_valid high in the next cycle. Writes to indices 2 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_err_valid | input | 1 | Decode fault pulse |
| dec_err_client | input | 6 | Client ID of the decode fault |
| dec_err_write | input | 1 | Decode fault is a write |
| dec_err_addr | input | ADDR_W | Decode fault address |
| page_err_valid | input | 1 | Invalid-page fault pulse |
| page_err_client | input | 6 | Client ID of the page fault |
| page_err_write | input | 1 | Page fault is a write |
| page_err_addr | input | ADDR_W | Page fault address |
| sec_err_valid | input | 1 | Security fault pulse |
| sec_err_client | input | 6 | Client ID of the security fault |
| sec_err_write | input | 1 | Security fault is a write |
| sec_err_kind | input | 1 | Security fault subtype |
| sec_err_addr | input | ADDR_W | Security fault address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rd_valid | output | 1 | Read data valid |
| irq | output | 1 | Registered interrupt |

## Verification
The assertions check these rules on every cycle for all three slots:
- a fault sets its pending bit;
- a clear with no competing fault drops the bit;
- a pending slot's words stay frozen;
- irq follows the masked pending bits with one cycle of delay;
- every read is answered in the next cycle.

Only the bench scenarios can show the bit layout of each kind's status word and that the address sits in the word after its status word. The same holds for mask selectivity per bit, the clear-versus-new-fault collision, and writes to read-only words leaving the contents intact.

// File: rtl/memerr_pkg.sv
package memerr_pkg;

    localparam int CLIENT_W  = 6;
    localparam int WORD_W    = 32;
    localparam int NUM_KINDS = 3;
    localparam int REG_IDX_W = 3;

    localparam int KIND_DECODE = 0;
    localparam int KIND_PAGE   = 1;
    localparam int KIND_SECURE = 2;

    localparam logic [REG_IDX_W-1:0] IDX_IRQ_STAT = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_IRQ_MASK = 3'd1;

    typedef struct packed {
        logic                write;
        logic                subtype;
        logic [CLIENT_W-1:0] client;
    } err_info_t;

    // Each fault kind has its own status-word layout.
    function automatic logic [WORD_W-1:0] pack_status(input int kind, input err_info_t info);
        logic [WORD_W-1:0] w;
        w = '0;
        case (kind)
            KIND_PAGE: begin
                w[0]            = info.write;
                w[CLIENT_W:1]   = info.client;
            end
            KIND_SECURE: begin
                w[CLIENT_W-1:0] = info.client;
                w[30]           = info.subtype;
                w[31]           = info.write;
            end
            default: begin
                w[CLIENT_W-1:0] = info.client;
                w[31]           = info.write;
            end
        endcase
        return w;
    endfunction

    function automatic logic [REG_IDX_W-1:0] stat_index(input int kind);
        return REG_IDX_W'(2 + 2 * kind);
    endfunction

endpackage

// File: rtl/memerr_slot.sv
module memerr_slot
    import memerr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KIND   = KIND_DECODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid,
    input  err_info_t         err_info,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              clear,
    output logic              pending,
    output logic [WORD_W-1:0] stat_word,
    output logic [WORD_W-1:0] addr_word
);

    logic              pending_q;
    err_info_t         info_q;
    logic [ADDR_W-1:0] addr_q;
    logic              take;

    // A slot accepts a fault when it is free or is being freed this cycle.
    assign take = err_valid && (!pending_q || clear);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            info_q    <= '0;
            addr_q    <= '0;
        end else begin
            if (take) begin
                pending_q <= 1'b1;
                info_q    <= err_info;
                addr_q    <= err_addr;
            end else if (clear) begin
                pending_q <= 1'b0;
            end
        end
    end

    always_comb begin
        addr_word              = '0;
        addr_word[ADDR_W-1:0]  = addr_q;
    end

    assign stat_word = pack_status(KIND, info_q);
    assign pending   = pending_q;

endmodule

// File: rtl/memerr_regs.sv
module memerr_regs
    import memerr_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                reg_wr_en,
    input  logic                                reg_rd_en,
    input  logic [REG_IDX_W-1:0]                reg_idx,
    input  logic [WORD_W-1:0]                   reg_wdata,
    input  logic [NUM_KINDS-1:0]                pending,
    input  logic [NUM_KINDS-1:0][WORD_W-1:0]    stat_words,
    input  logic [NUM_KINDS-1:0][WORD_W-1:0]    addr_words,
    output logic [NUM_KINDS-1:0]                clear_vec,
    output logic [NUM_KINDS-1:0]                mask,
    output logic [WORD_W-1:0]                   reg_rdata,
    output logic                                reg_rd_valid
);

    logic [NUM_KINDS-1:0] mask_q;
    logic [WORD_W-1:0]    rd_mux;
    logic [WORD_W-1:0]    rdata_q;
    logic                 rvalid_q;

    assign clear_vec = (reg_wr_en && reg_idx == IDX_IRQ_STAT) ? reg_wdata[NUM_KINDS-1:0] : '0;

    always_comb begin
        rd_mux = '0;
        if (reg_idx == IDX_IRQ_STAT) begin
            rd_mux[NUM_KINDS-1:0] = pending;
        end else if (reg_idx == IDX_IRQ_MASK) begin
            rd_mux[NUM_KINDS-1:0] = mask_q;
        end
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (reg_idx == stat_index(k))                    rd_mux = stat_words[k];
            if (reg_idx == stat_index(k) + REG_IDX_W'(1))    rd_mux = addr_words[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (reg_wr_en && reg_idx == IDX_IRQ_MASK) mask_q <= reg_wdata[NUM_KINDS-1:0];
            rvalid_q <= reg_rd_en;
            if (reg_rd_en) rdata_q <= rd_mux;
        end
    end

    assign mask         = mask_q;
    assign reg_rdata    = rdata_q;
    assign reg_rd_valid = rvalid_q;

endmodule

// File: rtl/memerr_irq.sv
module memerr_irq
    import memerr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_KINDS-1:0] pending,
    input  logic [NUM_KINDS-1:0] mask,
    output logic                 irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pending & mask);
    end

    assign irq = irq_q;

endmodule

// File: rtl/memerr_unit.sv
module memerr_unit
    import memerr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dec_err_valid,
    input  logic [CLIENT_W-1:0]  dec_err_client,
    input  logic                 dec_err_write,
    input  logic [ADDR_W-1:0]    dec_err_addr,
    input  logic                 page_err_valid,
    input  logic [CLIENT_W-1:0]  page_err_client,
    input  logic                 page_err_write,
    input  logic [ADDR_W-1:0]    page_err_addr,
    input  logic                 sec_err_valid,
    input  logic [CLIENT_W-1:0]  sec_err_client,
    input  logic                 sec_err_write,
    input  logic                 sec_err_kind,
    input  logic [ADDR_W-1:0]    sec_err_addr,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_en,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 reg_rd_valid,
    output logic                 irq
);

    logic [NUM_KINDS-1:0]             err_valid;
    err_info_t                        err_info [NUM_KINDS];
    logic [ADDR_W-1:0]                err_addr [NUM_KINDS];
    logic [NUM_KINDS-1:0]             pending;
    logic [NUM_KINDS-1:0]             clear_vec;
    logic [NUM_KINDS-1:0]             mask;
    logic [NUM_KINDS-1:0][WORD_W-1:0] stat_words;
    logic [NUM_KINDS-1:0][WORD_W-1:0] addr_words;

    assign err_valid = {sec_err_valid, page_err_valid, dec_err_valid};

    assign err_info[KIND_DECODE] = '{write: dec_err_write,  subtype: 1'b0,         client: dec_err_client};
    assign err_info[KIND_PAGE]   = '{write: page_err_write, subtype: 1'b0,         client: page_err_client};
    assign err_info[KIND_SECURE] = '{write: sec_err_write,  subtype: sec_err_kind, client: sec_err_client};

    assign err_addr[KIND_DECODE] = dec_err_addr;
    assign err_addr[KIND_PAGE]   = page_err_addr;
    assign err_addr[KIND_SECURE] = sec_err_addr;

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_slot
        memerr_slot #(
            .ADDR_W (ADDR_W),
            .KIND   (g)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .err_valid (err_valid[g]),
            .err_info  (err_info[g]),
            .err_addr  (err_addr[g]),
            .clear     (clear_vec[g]),
            .pending   (pending[g]),
            .stat_word (stat_words[g]),
            .addr_word (addr_words[g])
        );
    end

    memerr_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_wr_en    (reg_wr_en),
        .reg_rd_en    (reg_rd_en),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .pending      (pending),
        .stat_words   (stat_words),
        .addr_words   (addr_words),
        .clear_vec    (clear_vec),
        .mask         (mask),
        .reg_rdata    (reg_rdata),
        .reg_rd_valid (reg_rd_valid)
    );

    memerr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .mask    (mask),
        .irq     (irq)
    );

endmodule

// File: rtl/memerr_checker.sv
module memerr_checker
    import memerr_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_KINDS-1:0]             err_valid,
    input logic [NUM_KINDS-1:0]             clear_vec,
    input logic [NUM_KINDS-1:0]             pending,
    input logic [NUM_KINDS-1:0]             mask,
    input logic [NUM_KINDS-1:0][WORD_W-1:0] stat_words,
    input logic [NUM_KINDS-1:0][WORD_W-1:0] addr_words,
    input logic                             reg_rd_en,
    input logic                             reg_rd_valid,
    input logic                             irq
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pending == '0 && mask == '0 && !irq && !reg_rd_valid));

    a_r10_irq_follows_mask: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(pending & mask))));

    a_r11_read_answered: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> reg_rd_valid);

    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> !reg_rd_valid);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        a_r6_fault_sets_bit: assert property (@(posedge clk) disable iff (rst)
            err_valid[k] |=> pending[k]);

        a_r8_clear_drops_bit: assert property (@(posedge clk) disable iff (rst)
            (clear_vec[k] && !err_valid[k]) |=> !pending[k]);

        a_r7_first_fault_held: assert property (@(posedge clk) disable iff (rst)
            (pending[k] && !clear_vec[k]) |=> ($stable(stat_words[k]) && $stable(addr_words[k])));
    end

endmodule

bind memerr_unit memerr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .err_valid    (err_valid),
    .clear_vec    (clear_vec),
    .pending      (pending),
    .mask         (mask),
    .stat_words   (stat_words),
    .addr_words   (addr_words),
    .reg_rd_en    (reg_rd_en),
    .reg_rd_valid (reg_rd_valid),
    .irq          (irq)
);

// File: tb/tb_memerr_unit.sv
module tb_memerr_unit;
    import memerr_pkg::*;

    localparam int AW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst = 1'b1;
    logic                 dec_err_valid = 0, page_err_valid = 0, sec_err_valid = 0;
    logic [CLIENT_W-1:0]  dec_err_client = '0, page_err_client = '0, sec_err_client = '0;
    logic                 dec_err_write = 0, page_err_write = 0, sec_err_write = 0, sec_err_kind = 0;
    logic [AW-1:0]        dec_err_addr = '0, page_err_addr = '0, sec_err_addr = '0;
    logic                 reg_wr_en = 0, reg_rd_en = 0;
    logic [REG_IDX_W-1:0] reg_idx = '0;
    logic [WORD_W-1:0]    reg_wdata = '0;
    logic [WORD_W-1:0]    reg_rdata;
    logic                 reg_rd_valid;
    logic                 irq;

    memerr_unit #(.ADDR_W(AW)) dut (.*);

    typedef struct {
        logic [WORD_W-1:0] exp;
        string             req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as the design returns it.
    always @(negedge clk) begin
        if (!rst && reg_rd_valid) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected read data actual=%h expected=none", reg_rdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.req, reg_rdata, e.exp);
            end
        end
    end

    task automatic reg_write(input logic [REG_IDX_W-1:0] idx, input logic [WORD_W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic reg_read(input logic [REG_IDX_W-1:0] idx, input logic [WORD_W-1:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        reg_rd_en = 1; reg_idx = idx;
        e.exp = exp; e.req = req;
        q.push_back(e);
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic dec_fault(input logic [5:0] c, input logic w, input logic [AW-1:0] a);
        @(negedge clk);
        dec_err_valid = 1; dec_err_client = c; dec_err_write = w; dec_err_addr = a;
        @(negedge clk);
        dec_err_valid = 0;
    endtask

    task automatic page_fault(input logic [5:0] c, input logic w, input logic [AW-1:0] a);
        @(negedge clk);
        page_err_valid = 1; page_err_client = c; page_err_write = w; page_err_addr = a;
        @(negedge clk);
        page_err_valid = 0;
    endtask

    task automatic sec_fault(input logic [5:0] c, input logic w, input logic s, input logic [AW-1:0] a);
        @(negedge clk);
        sec_err_valid = 1; sec_err_client = c; sec_err_write = w; sec_err_kind = s; sec_err_addr = a;
        @(negedge clk);
        sec_err_valid = 0;
    endtask

    task automatic check_irq(input logic exp, input string req);
        @(negedge clk);
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 rd_valid after reset", {31'b0, reg_rd_valid}, 32'h0);
        rst = 0;
        reg_read(3'd0, 32'h0, "R1 pending bits");
        reg_read(3'd1, 32'h0, "R1 mask word");
        reg_read(3'd2, 32'h0, "R1 decode status");
        reg_read(3'd7, 32'h0, "R1 security address");

        // Decode fault, masked.
        dec_fault(6'h2A, 1'b1, 32'h8000_1234);
        reg_read(3'd2, 32'h8000_002A, "R2 decode status layout");
        reg_read(3'd3, 32'h8000_1234, "R5 decode address");
        reg_read(3'd0, 32'h1, "R6 decode bit");
        check_irq(1'b0, "R10 masked irq low");

        reg_write(3'd1, 32'h7);
        check_irq(1'b1, "R10 unmasked irq high");
        reg_read(3'd1, 32'h7, "R10 mask readback");

        // Second decode fault while pending: held.
        dec_fault(6'h05, 1'b0, 32'h0000_1111);
        reg_read(3'd2, 32'h8000_002A, "R7 decode status held");
        reg_read(3'd3, 32'h8000_1234, "R7 decode address held");

        // Clear with zeros at bit 0 keeps it; ones clear it.
        reg_write(3'd0, 32'h6);
        reg_read(3'd0, 32'h1, "R8 unwritten bit kept");
        reg_write(3'd0, 32'h1);
        reg_read(3'd0, 32'h0, "R8 written bit cleared");
        check_irq(1'b0, "R10 irq drops after clear");

        // Page faults.
        page_fault(6'h3F, 1'b1, 32'h0000_0040);
        reg_read(3'd4, 32'h0000_007F, "R3 page status write");
        reg_read(3'd5, 32'h0000_0040, "R5 page address");
        reg_write(3'd0, 32'h2);
        page_fault(6'h11, 1'b0, 32'h0000_0ABC);
        reg_read(3'd4, 32'h0000_0022, "R3 page status read");
        reg_read(3'd5, 32'h0000_0ABC, "R5 page address second");

        // Security fault.
        sec_fault(6'h15, 1'b1, 1'b1, 32'hDEAD_BEE0);
        reg_read(3'd6, 32'hC000_0015, "R4 security status");
        reg_read(3'd7, 32'hDEAD_BEE0, "R5 security address");
        reg_read(3'd0, 32'h6, "R6 page and security bits");

        // Fault in the same cycle as its clear.
        @(negedge clk);
        sec_err_valid = 1; sec_err_client = 6'h03; sec_err_write = 0; sec_err_kind = 0; sec_err_addr = 32'h10;
        reg_wr_en = 1; reg_idx = 3'd0; reg_wdata = 32'h4;
        @(negedge clk);
        sec_err_valid = 0; reg_wr_en = 0;
        reg_read(3'd0, 32'h6, "R9 bit stays set");
        reg_read(3'd6, 32'h0000_0003, "R9 new status captured");
        reg_read(3'd7, 32'h0000_0010, "R9 new address captured");

        // Read-only words ignore writes.
        reg_write(3'd2, 32'hFFFF_FFFF);
        reg_write(3'd7, 32'h0);
        reg_read(3'd2, 32'h8000_002A, "R11 decode status unwritable");
        reg_read(3'd7, 32'h0000_0010, "R11 address unwritable");

        // Mask selectivity.
        reg_write(3'd1, 32'h1);
        check_irq(1'b0, "R10 only unpending bit unmasked");
        reg_write(3'd1, 32'h4);
        check_irq(1'b1, "R10 security bit unmasked");

        reg_write(3'd0, 32'h7);
        check_irq(1'b0, "R8 all cleared irq low");

        // All three kinds in one cycle.
        @(negedge clk);
        dec_err_valid = 1; page_err_valid = 1; sec_err_valid = 1;
        dec_err_client = 6'h01; dec_err_write = 0; dec_err_addr = 32'h100;
        @(negedge clk);
        dec_err_valid = 0; page_err_valid = 0; sec_err_valid = 0;
        reg_read(3'd0, 32'h7, "R6 simultaneous faults");
        reg_read(3'd2, 32'h0000_0001, "R2 decode read direction");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 reads unanswered actual=%0d expected=0", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule